// File: doc/BRIEF.md
# Power Sprint Cap Controller

The controller sets the power cap for a processing-in-memory array. In its normal phase it passes a nominal cap through to `cap_o`. When a sprint is requested, the cap is raised to a boost value for a programmed number of cycles. After that it asserts a pause broadcast to the subtask queue and to the running processing units. The pause is held until the measured consumption has fallen to or below the nominal cap.

A recovery window at the nominal cap then follows. It lasts a programmed number of cycles, and no new sprint can start until it is over. Both window lengths are cycle counts taken from configuration inputs. A length of zero disables sprinting. The block does no thermal modelling and holds no energy storage. It only sequences the cap and the pause.

Top module: `sprint_cap_ctrl`

## Requirements
- R1: After reset the controller is in its normal phase. In that phase `cap_o` equals `nominal_cap_i` in the same cycle, `pause_o` is low, and `sprint_avail_o` is high when both length inputs are nonzero.
- R2: A request sampled at a clock edge in the normal phase, with both lengths nonzero, starts a sprint. From the next cycle `cap_o` equals `boost_cap_i` for exactly `sprint_len_i` cycles. The sprint length is sampled at the request edge.
- R3: When the sprint ends, the controller enters a drain phase. In that phase `pause_o` is high and `cap_o` equals `nominal_cap_i`. The phase lasts at least one cycle and ends at the first edge where `power_meas_i <= nominal_cap_i`. The comparison is inclusive.
- R4: After the drain, a recovery phase of exactly `recover_len_i` cycles follows. During it `cap_o` equals the nominal cap and `pause_o` and `sprint_avail_o` are low. `recover_len_i` is sampled at the edge that ends the drain. The controller then returns to the normal phase.
- R5: `sprint_avail_o` is high only in the normal phase and only while both lengths are nonzero. It is low during sprint, drain and recovery.
- R6: A request made during sprint, drain or recovery is ignored. It neither lengthens nor restarts any phase.
- R7: If either length input is zero, a request in the normal phase has no effect. The cap stays nominal and `pause_o` stays low.
- R8: `pause_o` is high only in the drain phase, so pause and the boosted cap never appear together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sprint_req_i | input | 1 | Sprint request, sampled at each edge |
| sprint_len_i | input | CNT_W | Sprint window length in cycles |
| recover_len_i | input | CNT_W | Recovery window length in cycles |
| nominal_cap_i | input | CAP_W | Nominal power cap |
| boost_cap_i | input | CAP_W | Raised cap used during a sprint |
| power_meas_i | input | CAP_W | Measured power consumption |
| cap_o | output | CAP_W | Cap currently in force |
| pause_o | output | 1 | Pause broadcast to queue and processing units |
| sprint_avail_o | output | 1 | A sprint may be started now |

## Verification
The bench checks the exact length of each phase for several pairs of lengths, including windows of one cycle. An off-by-one timer would stretch or shorten the boost or the recovery by a cycle. In some runs the request is held high for the whole sequence. A controller that accepts requests outside the normal phase would then restart the sprint or cut recovery short. The drain is checked with measured power held above nominal for several cycles, and then exactly at nominal. An exclusive comparison would leave pause stuck on, and a drain that skips the check would drop pause while consumption is still high. Zero lengths are applied while a request is made, and reset is applied in the middle of a sprint.

// File: rtl/sprint_cap_pkg.sv
package sprint_cap_pkg;
  typedef enum logic [1:0] {
    PH_NORMAL  = 2'd0,
    PH_SPRINT  = 2'd1,
    PH_DRAIN   = 2'd2,
    PH_RECOVER = 2'd3
  } phase_e;
endpackage

// File: rtl/sprint_phase_timer.sv
module sprint_phase_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sprint_phase_fsm.sv
module sprint_phase_fsm
  import sprint_cap_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned CAP_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sprint_req_i,
  input  logic             start_ok_i,
  input  logic [CNT_W-1:0] sprint_len_i,
  input  logic [CNT_W-1:0] recover_len_i,
  input  logic [CAP_W-1:0] nominal_cap_i,
  input  logic [CAP_W-1:0] power_meas_i,
  input  logic             timer_zero_i,
  output logic             timer_load_o,
  output logic [CNT_W-1:0] timer_val_o,
  output phase_e           phase_o
);
  phase_e phase_q, phase_d;
  logic   drained;

  assign drained = (power_meas_i <= nominal_cap_i);

  always_comb begin
    phase_d      = phase_q;
    timer_load_o = 1'b0;
    timer_val_o  = '0;
    unique case (phase_q)
      PH_NORMAL: if (sprint_req_i && start_ok_i) begin
        phase_d      = PH_SPRINT;
        timer_load_o = 1'b1;
        timer_val_o  = sprint_len_i - 1'b1;
      end
      PH_SPRINT: if (timer_zero_i) phase_d = PH_DRAIN;
      PH_DRAIN: if (drained) begin
        phase_d      = PH_RECOVER;
        timer_load_o = 1'b1;
        // zero recovery length still costs one cycle
        timer_val_o  = (recover_len_i == '0) ? '0 : recover_len_i - 1'b1;
      end
      PH_RECOVER: if (timer_zero_i) phase_d = PH_NORMAL;
      default: phase_d = PH_NORMAL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_NORMAL;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/sprint_cap_mux.sv
module sprint_cap_mux
  import sprint_cap_pkg::*;
#(
  parameter int unsigned CAP_W = 12
) (
  input  phase_e           phase_i,
  input  logic             start_ok_i,
  input  logic [CAP_W-1:0] nominal_cap_i,
  input  logic [CAP_W-1:0] boost_cap_i,
  output logic [CAP_W-1:0] cap_o,
  output logic             pause_o,
  output logic             avail_o
);
  always_comb begin
    cap_o   = nominal_cap_i;
    pause_o = 1'b0;
    avail_o = 1'b0;
    unique case (phase_i)
      PH_NORMAL:  avail_o = start_ok_i;
      PH_SPRINT:  cap_o   = boost_cap_i;
      PH_DRAIN:   pause_o = 1'b1;
      PH_RECOVER: ;
      default:    ;
    endcase
  end
endmodule

// File: rtl/sprint_cap_ctrl.sv
module sprint_cap_ctrl
  import sprint_cap_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned CAP_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sprint_req_i,
  input  logic [CNT_W-1:0] sprint_len_i,
  input  logic [CNT_W-1:0] recover_len_i,
  input  logic [CAP_W-1:0] nominal_cap_i,
  input  logic [CAP_W-1:0] boost_cap_i,
  input  logic [CAP_W-1:0] power_meas_i,
  output logic [CAP_W-1:0] cap_o,
  output logic             pause_o,
  output logic             sprint_avail_o
);
  phase_e           phase;
  logic             start_ok;
  logic             timer_load;
  logic             timer_zero;
  logic [CNT_W-1:0] timer_val;

  assign start_ok = (sprint_len_i != '0) && (recover_len_i != '0);

  sprint_phase_fsm #(.CNT_W(CNT_W), .CAP_W(CAP_W)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sprint_req_i  (sprint_req_i),
    .start_ok_i    (start_ok),
    .sprint_len_i  (sprint_len_i),
    .recover_len_i (recover_len_i),
    .nominal_cap_i (nominal_cap_i),
    .power_meas_i  (power_meas_i),
    .timer_zero_i  (timer_zero),
    .timer_load_o  (timer_load),
    .timer_val_o   (timer_val),
    .phase_o       (phase)
  );

  sprint_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (timer_load),
    .load_val_i (timer_val),
    .zero_o     (timer_zero)
  );

  sprint_cap_mux #(.CAP_W(CAP_W)) u_mux (
    .phase_i       (phase),
    .start_ok_i    (start_ok),
    .nominal_cap_i (nominal_cap_i),
    .boost_cap_i   (boost_cap_i),
    .cap_o         (cap_o),
    .pause_o       (pause_o),
    .avail_o       (sprint_avail_o)
  );
endmodule

// File: rtl/sprint_cap_ctrl_checker.sv
module sprint_cap_ctrl_checker
  import sprint_cap_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned CAP_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input phase_e           phase,
  input logic             sprint_req_i,
  input logic [CNT_W-1:0] sprint_len_i,
  input logic [CNT_W-1:0] recover_len_i,
  input logic [CAP_W-1:0] nominal_cap_i,
  input logic [CAP_W-1:0] power_meas_i,
  input logic [CAP_W-1:0] cap_o,
  input logic             pause_o,
  input logic             sprint_avail_o
);
  logic zero_len;
  assign zero_len = (sprint_len_i == '0) || (recover_len_i == '0);

  AST_START_SPRINT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sprint_avail_o && sprint_req_i) |=> (phase == PH_SPRINT)); // R2

  AST_NO_RESPRINT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_DRAIN || phase == PH_RECOVER) |=> (phase != PH_SPRINT)); // R6

  AST_SPRINT_TO_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_SPRINT) |=> (phase == PH_SPRINT || phase == PH_DRAIN)); // R3

  AST_DRAIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pause_o && power_meas_i > nominal_cap_i) |=> pause_o); // R3

  AST_ZERO_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_NORMAL && zero_len) |=> (phase == PH_NORMAL)); // R7

  AST_RECOVER_NOMINAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_RECOVER) |-> (cap_o == nominal_cap_i && !pause_o && !sprint_avail_o)); // R4

  AST_PAUSE_AFTER_SPRINT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pause_o) |-> ($past(phase) == PH_SPRINT)); // R8
endmodule

bind sprint_cap_ctrl sprint_cap_ctrl_checker #(.CNT_W(CNT_W), .CAP_W(CAP_W)) u_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .phase          (phase),
  .sprint_req_i   (sprint_req_i),
  .sprint_len_i   (sprint_len_i),
  .recover_len_i  (recover_len_i),
  .nominal_cap_i  (nominal_cap_i),
  .power_meas_i   (power_meas_i),
  .cap_o          (cap_o),
  .pause_o        (pause_o),
  .sprint_avail_o (sprint_avail_o)
);

// File: tb/sprint_cap_ctrl_bench.sv
module sprint_cap_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int CAP_W = 12;
  localparam logic [CAP_W-1:0] NOM   = 12'd100;
  localparam logic [CAP_W-1:0] BOOST = 12'd180;
  localparam logic [CAP_W-1:0] HIGH  = 12'd150;
  localparam int NVEC = 6;
  // {sprint_len, recover_len, extra drain cycles, hold request}
  localparam logic [63:0] VEC [NVEC] = '{
    {16'd1, 16'd1, 16'd0, 16'd0},
    {16'd3, 16'd2, 16'd0, 16'd1},
    {16'd5, 16'd4, 16'd2, 16'd0},
    {16'd2, 16'd6, 16'd1, 16'd1},
    {16'd8, 16'd3, 16'd3, 16'd1},
    {16'd1, 16'd1, 16'd4, 16'd1}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req = 1'b0;
  logic [CNT_W-1:0] slen = 16'd4;
  logic [CNT_W-1:0] rlen = 16'd4;
  logic [CAP_W-1:0] nom = NOM;
  logic [CAP_W-1:0] boost = BOOST;
  logic [CAP_W-1:0] meas = NOM;
  logic [CAP_W-1:0] cap;
  logic             pause;
  logic             avail;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sprint_cap_ctrl #(.CNT_W(CNT_W), .CAP_W(CAP_W)) u_sprint_cap_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sprint_req_i(req),
    .sprint_len_i(slen), .recover_len_i(rlen),
    .nominal_cap_i(nom), .boost_cap_i(boost), .power_meas_i(meas),
    .cap_o(cap), .pause_o(pause), .sprint_avail_o(avail)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_vec(input int sl, input int rl, input int extra, input bit hold);
    int n;
    slen = CNT_W'(sl); rlen = CNT_W'(rl); meas = HIGH; req = 1'b1;
    @(negedge clk);
    if (!hold) req = 1'b0;
    n = 0;
    while (cap == BOOST && n < 1000) begin
      check(!avail && !pause, "R5 avail/pause low in sprint", int'({avail, pause}), 0);
      n++;
      @(negedge clk);
    end
    check(n == sl, "R2 sprint length", n, sl);
    check(cap == NOM, "R3 cap nominal in drain", int'(cap), int'(NOM));
    n = 0;
    while (pause && n < 1000) begin
      n++;
      if (n > extra) meas = NOM;  // boundary: equal counts as drained
      @(negedge clk);
    end
    check(n == extra + 1, "R3 pause cycles", n, extra + 1);
    n = 0;
    while (!avail && !pause && cap == NOM && n < 1000) begin
      n++;
      @(negedge clk);
    end
    check(n == rl, "R4 recovery length", n, rl);
    check(hold ? n == rl : 1'b1, "R6 held request ignored", n, rl);
    check(avail && cap == NOM, "R5 avail back in normal", int'(avail), 1);
    req = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check(cap == NOM && !pause && avail, "R1 reset state", int'({cap, pause, avail}), int'({NOM, 1'b0, 1'b1}));
    rst_n = 1'b1;
    @(negedge clk);
    check(cap == NOM && !pause && avail, "R1 normal after reset", int'({cap, pause, avail}), int'({NOM, 1'b0, 1'b1}));

    for (int i = 0; i < NVEC; i++)
      run_vec(int'(VEC[i][63:48]), int'(VEC[i][47:32]), int'(VEC[i][31:16]), VEC[i][0]);

    // R1: cap follows nominal input combinationally in normal phase
    nom = 12'd120;
    #1 check(cap == 12'd120, "R1 nominal tracked", int'(cap), 120);
    nom = NOM;

    // R7: zero sprint length
    slen = '0; rlen = 16'd3; meas = HIGH;
    #1 check(!avail, "R5 avail low with zero length", int'(avail), 0);
    req = 1'b1;
    repeat (2) @(negedge clk);
    req = 1'b0;
    check(cap == NOM && !pause, "R7 zero sprint length ignored", int'(cap), int'(NOM));
    // R7: zero recovery length
    slen = 16'd4; rlen = '0;
    req = 1'b1;
    repeat (2) @(negedge clk);
    req = 1'b0;
    check(cap == NOM && !pause && !avail, "R7 zero recovery length ignored", int'(cap), int'(NOM));

    // R8: pause only after sprint, never with boost
    rlen = 16'd2; meas = HIGH;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    check(cap == BOOST && !pause, "R8 no pause during sprint", int'(pause), 0);
    repeat (4) @(negedge clk);
    check(pause && cap == NOM, "R8 pause after sprint", int'(pause), 1);
    repeat (3) @(negedge clk);
    check(pause, "R3 pause held while over cap", int'(pause), 1);
    meas = NOM;
    repeat (4) @(negedge clk);
    check(avail && !pause, "R4 back to normal", int'(avail), 1);

    // R1: reset in the middle of a sprint
    meas = HIGH; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    check(cap == BOOST, "R2 sprint started", int'(cap), int'(BOOST));
    rst_n = 1'b0;
    #1 check(cap == NOM && !pause && avail, "R1 reset mid-sprint", int'(cap), int'(NOM));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule